// File: doc/BRIEF.md
# Memory-Mapped Block-RAM Bridge with Access Statistics

This block is an AXI4-Lite slave that serves single-beat reads and writes from a single-port synchronous RAM of 2048 words of 32 bits. The RAM sits inside the block, and its port (enable, 4-bit write enable, word address, write data and read data) is also brought out as observation outputs, so the RAM timing can be watched from outside. The RAM has a fixed two-cycle read latency. The bridge runs each transaction through a short sequence that respects this latency, and it never has more than one transaction open.

The three lowest word addresses are not backed by RAM. They are registers that report how many writes and reads have been accepted and whether software ever tried to overwrite one of them. A word address past the end of the array is folded back into it by a modulo. When a write and a read arrive together, the write is served first.

Top module: `axil_ram_bridge`

## Requirements
- R1: After reset is released, the RAM enable output is high on every cycle.
- R2: The RAM write-enable output only takes the codes 4'b0000 (read or idle) and 4'b1111 (full-word write). It is 4'b0000 during every read sequence.
- R3: A write is accepted at the first rising edge where AWVALID, AWREADY, WVALID and WREADY are all high. For the two following cycles the write enable is 4'b1111, with the folded word address on the RAM address and WDATA on the RAM data input. After those two cycles the write enable returns to 4'b0000 and BVALID rises.
- R4: BVALID stays high until a cycle with BREADY high, and BRESP is always 2'b00.
- R5: A read is accepted when ARVALID and ARREADY are high. RVALID rises at the third rising edge after that handshake edge and carries the addressed word. RVALID and RDATA hold until RREADY, and RRESP is always 2'b00.
- R6: When AWVALID and WVALID are both high in an idle cycle, ARREADY is low, so the write is served before a pending read.
- R7: A read of word 0 returns the number of writes accepted since reset. A read of word 1 returns the number of reads accepted since reset, counting the read itself. A read of word 2 returns the error word.
- R8: A write to word 0, 1 or 2 is still counted and still answered with BVALID. It leaves the RAM write enable at 4'b0000 and sets the error word to 1, and the error word then stays 1 until reset.
- R9: The word address is the byte address with its two low bits dropped. A word address above 2047 is replaced by itself modulo 2047 (for example, word 2050 reaches word 3).
- R10: Only one transaction is open at a time. While a write or read sequence or a response is pending, AWREADY, WREADY and ARREADY are low, and BVALID and RVALID are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | 32 | Write byte address |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | 32 | Write data |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_araddr | input | 32 | Read byte address |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| mem_en_o | output | 1 | RAM enable (observation) |
| mem_we_o | output | 4 | RAM write enable (observation) |
| mem_addr_o | output | 11 | RAM word address (observation) |
| mem_wdata_o | output | 32 | RAM write data (observation) |
| mem_rdata_o | output | 32 | RAM read data (observation) |

## Verification
The assertions check the local timing rules on every cycle: the enable stays high, the write enable only takes its two codes and is high for exactly two cycles before the write response, responses hold until their ready, ready signals are low while a transaction is open, and write enable never reaches a reserved word. Some properties depend on values and history, and only the bench's scenarios can show them. These are the data read back after writes to random and aliased addresses, the modulo-2047 folding, the counter and error-word values, the three-edge read latency and the write-first order when both requests arrive together.

// File: rtl/axil_ram_pkg.sv
package axil_ram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR,
    ST_WRSP,
    ST_RD,
    ST_RCAP,
    ST_RRSP
  } seq_st_t;

  localparam logic [1:0] RESP_OKAY = 2'b00;

endpackage

// File: rtl/axil_ram_store.sv
module axil_ram_store #(
  parameter int DW     = 32,
  parameter int DEPTH  = 2048,
  parameter int RD_LAT = 2,
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          en,
  input  logic [3:0]    we,
  input  logic [IW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] pipe_q [RD_LAT];

  logic wr_en;
  assign wr_en = en && (&we);

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[addr] <= din;
    end
  end

  generate
    for (genvar s = 0; s < RD_LAT; s++) begin : g_rd_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (en) begin
            pipe_q[0] <= mem_q[addr];
          end
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (en) begin
            pipe_q[s] <= pipe_q[s-1];
          end
        end
      end
    end
  endgenerate

  assign dout = pipe_q[RD_LAT-1];

endmodule

// File: rtl/axil_ram_stats.sv
module axil_ram_stats #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_acc,
  input  logic          rd_acc,
  input  logic          wr_res,
  input  logic [1:0]    sel,
  output logic [DW-1:0] val
);

  logic [DW-1:0] wcnt_q, wcnt_d;
  logic [DW-1:0] rcnt_q, rcnt_d;
  logic          err_q, err_d;

  always_comb begin
    wcnt_d = wcnt_q + DW'(1);
    rcnt_d = rcnt_q + DW'(1);
    err_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q <= '0;
      rcnt_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (wr_acc) wcnt_q <= wcnt_d;
      if (rd_acc) rcnt_q <= rcnt_d;
      if (wr_res) err_q  <= err_d;
    end
  end

  always_comb begin
    case (sel)
      2'd0:    val = wcnt_q;
      2'd1:    val = rcnt_q;
      default: val = {{(DW-1){1'b0}}, err_q};
    endcase
  end

endmodule

// File: rtl/axil_ram_seq.sv
module axil_ram_seq
  import axil_ram_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int DEPTH  = 2048,
  parameter int WR_CYC = 2,
  parameter int RD_LAT = 2,
  parameter int NRES   = 3,
  localparam int IW    = $clog2(DEPTH),
  localparam int MAXC  = (WR_CYC > RD_LAT) ? WR_CYC : RD_LAT,
  localparam int CW    = $clog2(MAXC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          awvalid,
  output logic          awready,
  input  logic [AW-1:0] awaddr,
  input  logic          wvalid,
  output logic          wready,
  input  logic [DW-1:0] wdata,
  output logic          bvalid,
  input  logic          bready,
  output logic [1:0]    bresp,
  input  logic          arvalid,
  output logic          arready,
  input  logic [AW-1:0] araddr,
  output logic          rvalid,
  input  logic          rready,
  output logic [DW-1:0] rdata,
  output logic [1:0]    rresp,
  output logic [3:0]    mem_we,
  output logic [IW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [1:0]    stat_sel,
  input  logic [DW-1:0] stat_val,
  output logic          wr_acc,
  output logic          rd_acc,
  output logic          wr_res
);

  localparam logic [AW-3:0] LASTW = (AW-2)'(DEPTH - 1);

  function automatic logic [IW-1:0] fold(input logic [AW-1:0] a);
    logic [AW-3:0] w;
    w = a[AW-1:2];
    if (w > LASTW) begin
      w = w % LASTW;
    end
    return w[IW-1:0];
  endfunction

  seq_st_t       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] addr_q, addr_d;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdata_q, rdata_d;
  logic          res_q, res_d;

  logic idle, wr_req, aw_go, ar_go, addr_en, rdata_en;

  always_comb begin
    idle     = (st_q == ST_IDLE);
    wr_req   = awvalid && wvalid;
    aw_go    = idle && wr_req;
    ar_go    = idle && !wr_req && arvalid;
    addr_en  = aw_go || ar_go;
    rdata_en = (st_q == ST_RCAP);
    addr_d   = aw_go ? fold(awaddr) : fold(araddr);
    res_d    = (addr_d < IW'(NRES));
    rdata_d  = res_q ? stat_val : mem_rdata;
  end

  always_comb begin
    st_d  = st_q;
    cnt_d = '0;
    case (st_q)
      ST_IDLE: begin
        if (aw_go)      st_d = ST_WR;
        else if (ar_go) st_d = ST_RD;
      end
      ST_WR: begin
        cnt_d = cnt_q + CW'(1);
        if (cnt_q == CW'(WR_CYC - 1)) begin
          st_d  = ST_WRSP;
          cnt_d = '0;
        end
      end
      ST_WRSP: if (bready) st_d = ST_IDLE;
      ST_RD: begin
        cnt_d = cnt_q + CW'(1);
        if (cnt_q == CW'(RD_LAT - 1)) begin
          st_d  = ST_RCAP;
          cnt_d = '0;
        end
      end
      ST_RCAP: st_d = ST_RRSP;
      ST_RRSP: if (rready) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      res_q   <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (addr_en) begin
        addr_q <= addr_d;
        res_q  <= res_d;
      end
      if (aw_go)    wdata_q <= wdata;
      if (rdata_en) rdata_q <= rdata_d;
    end
  end

  assign awready   = aw_go;
  assign wready    = aw_go;
  assign arready   = idle && !wr_req;
  assign bvalid    = (st_q == ST_WRSP);
  assign rvalid    = (st_q == ST_RRSP);
  assign bresp     = RESP_OKAY;
  assign rresp     = RESP_OKAY;
  assign rdata     = rdata_q;
  assign mem_we    = ((st_q == ST_WR) && !res_q) ? 4'b1111 : 4'b0000;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign stat_sel  = addr_q[1:0];
  assign wr_acc    = aw_go;
  assign rd_acc    = ar_go;
  assign wr_res    = aw_go && res_d;

endmodule

// File: rtl/axil_ram_bridge.sv
module axil_ram_bridge #(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int DEPTH  = 2048,
  parameter int WR_CYC = 2,
  parameter int RD_LAT = 2,
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_awvalid,
  output logic          s_awready,
  input  logic [AW-1:0] s_awaddr,
  input  logic          s_wvalid,
  output logic          s_wready,
  input  logic [DW-1:0] s_wdata,
  output logic          s_bvalid,
  input  logic          s_bready,
  output logic [1:0]    s_bresp,
  input  logic          s_arvalid,
  output logic          s_arready,
  input  logic [AW-1:0] s_araddr,
  output logic          s_rvalid,
  input  logic          s_rready,
  output logic [DW-1:0] s_rdata,
  output logic [1:0]    s_rresp,
  output logic          mem_en_o,
  output logic [3:0]    mem_we_o,
  output logic [IW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic [DW-1:0] mem_rdata_o
);

  logic          en_q;
  logic [1:0]    stat_sel;
  logic [DW-1:0] stat_val;
  logic          wr_acc, rd_acc, wr_res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= 1'b1;
  end

  assign mem_en_o = en_q;

  axil_ram_seq #(
    .AW(AW), .DW(DW), .DEPTH(DEPTH), .WR_CYC(WR_CYC), .RD_LAT(RD_LAT), .NRES(3)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .awvalid(s_awvalid), .awready(s_awready), .awaddr(s_awaddr),
    .wvalid(s_wvalid), .wready(s_wready), .wdata(s_wdata),
    .bvalid(s_bvalid), .bready(s_bready), .bresp(s_bresp),
    .arvalid(s_arvalid), .arready(s_arready), .araddr(s_araddr),
    .rvalid(s_rvalid), .rready(s_rready), .rdata(s_rdata), .rresp(s_rresp),
    .mem_we(mem_we_o), .mem_addr(mem_addr_o), .mem_wdata(mem_wdata_o),
    .mem_rdata(mem_rdata_o),
    .stat_sel(stat_sel), .stat_val(stat_val),
    .wr_acc(wr_acc), .rd_acc(rd_acc), .wr_res(wr_res)
  );

  axil_ram_stats #(.DW(DW)) u_stats (
    .clk(clk), .rst_n(rst_n),
    .wr_acc(wr_acc), .rd_acc(rd_acc), .wr_res(wr_res),
    .sel(stat_sel), .val(stat_val)
  );

  axil_ram_store #(.DW(DW), .DEPTH(DEPTH), .RD_LAT(RD_LAT)) u_store (
    .clk(clk), .en(en_q), .we(mem_we_o), .addr(mem_addr_o),
    .din(mem_wdata_o), .dout(mem_rdata_o)
  );

endmodule

// File: rtl/axil_ram_bridge_chk.sv
module axil_ram_bridge_chk #(
  parameter int DW = 32,
  parameter int IW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          awvalid,
  input logic          awready,
  input logic          wvalid,
  input logic          wready,
  input logic          arready,
  input logic          bvalid,
  input logic          bready,
  input logic [1:0]    bresp,
  input logic          rvalid,
  input logic          rready,
  input logic [DW-1:0] rdata,
  input logic [1:0]    rresp,
  input logic          mem_en,
  input logic [3:0]    mem_we,
  input logic [IW-1:0] mem_addr
);

  logic seen_clk;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_clk <= 1'b0;
    else        seen_clk <= 1'b1;
  end

  // R1
  mem_en_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_clk |-> mem_en);

  // R2
  we_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we == 4'b0000) || (mem_we == 4'b1111));

  // R3
  we_first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we == 4'b1111 && $past(mem_we) != 4'b1111) |=> (mem_we == 4'b1111));

  // R3
  we_end_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we == 4'b1111 && $past(mem_we) == 4'b1111) |=> (mem_we == 4'b0000 && bvalid));

  // R4
  b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid && !bready) |=> bvalid);

  // R4
  bresp_okay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid |-> (bresp == 2'b00));

  // R5
  r_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && !rready) |=> (rvalid && $stable(rdata)));

  // R5
  rresp_okay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> (rresp == 2'b00));

  // R6
  write_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(awvalid && wvalid && arready));

  // R8
  no_reserved_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we == 4'b1111) |-> (mem_addr > IW'(2)));

  // R10
  busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid || rvalid || mem_we != 4'b0000) |-> (!awready && !wready && !arready));

  // R10
  one_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bvalid && rvalid));

endmodule

bind axil_ram_bridge axil_ram_bridge_chk #(.DW(DW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .awvalid(s_awvalid), .awready(s_awready),
  .wvalid(s_wvalid), .wready(s_wready),
  .arready(s_arready),
  .bvalid(s_bvalid), .bready(s_bready), .bresp(s_bresp),
  .rvalid(s_rvalid), .rready(s_rready), .rdata(s_rdata), .rresp(s_rresp),
  .mem_en(mem_en_o), .mem_we(mem_we_o), .mem_addr(mem_addr_o)
);

// File: tb/test_axil_ram_bridge.sv
module test_axil_ram_bridge;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 2048;

  logic        clk, rst_n;
  logic        awvalid, awready, wvalid, wready, bvalid, bready;
  logic        arvalid, arready, rvalid, rready;
  logic [31:0] awaddr, wdata, araddr, rdata, mem_wdata, mem_rdata;
  logic [1:0]  bresp, rresp;
  logic        mem_en;
  logic [3:0]  mem_we;
  logic [10:0] mem_addr;

  axil_ram_bridge i_axil_ram_bridge (
    .clk(clk), .rst_n(rst_n),
    .s_awvalid(awvalid), .s_awready(awready), .s_awaddr(awaddr),
    .s_wvalid(wvalid), .s_wready(wready), .s_wdata(wdata),
    .s_bvalid(bvalid), .s_bready(bready), .s_bresp(bresp),
    .s_arvalid(arvalid), .s_arready(arready), .s_araddr(araddr),
    .s_rvalid(rvalid), .s_rready(rready), .s_rdata(rdata), .s_rresp(rresp),
    .mem_en_o(mem_en), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_o(mem_rdata)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int unsigned exp_mem [DEPTH];
  int unsigned wcnt = 0, rcnt = 0, errw = 0;
  int known_q [$];

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int fold(input logic [31:0] a);
    int unsigned w;
    w = a >> 2;
    if (w > DEPTH - 1) w = w % (DEPTH - 1);
    return int'(w);
  endfunction

  function automatic int unsigned expect_rd(input int w);
    if (w == 0) return wcnt;
    if (w == 1) return rcnt;
    if (w == 2) return errw;
    return exp_mem[w];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic axi_write(input logic [31:0] a, input logic [31:0] d, input bit hold);
    int w;
    bit res;
    w   = fold(a);
    res = (w < 3);
    @(negedge clk);
    awaddr = a; wdata = d; awvalid = 1'b1; wvalid = 1'b1; bready = !hold;
    #1;
    while (!(awready && wready)) begin
      @(negedge clk); #1;
    end
    @(posedge clk);
    @(negedge clk);
    awvalid = 1'b0; wvalid = 1'b0;
    wcnt++;
    if (res) errw = 1;
    else exp_mem[w] = d;
    chk("R3 we beat1", {28'd0, mem_we}, res ? 32'd0 : 32'hF);
    if (!res) begin
      chk("R3 ram addr", {21'd0, mem_addr}, w);
      chk("R3 ram wdata", mem_wdata, d);
    end
    chk("R3 no bvalid early", {31'd0, bvalid}, 0);
    @(negedge clk);
    chk("R3 we beat2", {28'd0, mem_we}, res ? 32'd0 : 32'hF);
    @(negedge clk);
    chk("R3 we released", {28'd0, mem_we}, 0);
    chk("R3 bvalid", {31'd0, bvalid}, 1);
    chk("R4 bresp", {30'd0, bresp}, 0);
    if (hold) begin
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        chk("R4 bvalid hold", {31'd0, bvalid}, 1);
      end
      bready = 1'b1;
    end
    @(negedge clk);
    chk("R4 bvalid drop", {31'd0, bvalid}, 0);
  endtask

  task automatic axi_read(input logic [31:0] a, input bit hold, input string tag);
    int w, k;
    logic [31:0] got;
    w = fold(a);
    @(negedge clk);
    araddr = a; arvalid = 1'b1; rready = !hold;
    #1;
    while (!arready) begin
      @(negedge clk); #1;
    end
    @(posedge clk);
    @(negedge clk);
    arvalid = 1'b0;
    rcnt++;
    chk("R2 we during read", {28'd0, mem_we}, 0);
    k = 1;
    while (!rvalid && k < 20) begin
      @(negedge clk); k++;
    end
    chk("R5 read latency", k, 4);
    chk(tag, rdata, expect_rd(w));
    chk("R5 rresp", {30'd0, rresp}, 0);
    got = rdata;
    if (hold) begin
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        chk("R5 rvalid hold", {31'd0, rvalid}, 1);
        chk("R5 rdata stable", rdata, got);
      end
      rready = 1'b1;
    end
    @(negedge clk);
    chk("R5 rvalid drop", {31'd0, rvalid}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240917));
    awvalid = 0; wvalid = 0; arvalid = 0; bready = 1; rready = 1;
    awaddr = 0; wdata = 0; araddr = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 enable after reset", {31'd0, mem_en}, 1);
    chk("R2 we idle", {28'd0, mem_we}, 0);
    chk("R4 no bvalid at reset", {31'd0, bvalid}, 0);
    chk("R5 no rvalid at reset", {31'd0, rvalid}, 0);
    chk("R10 awready idle no req", {31'd0, awready}, 0);

    // R7: statistics before any write
    axi_read(32'h8, 0, "R7 error word clear");
    axi_read(32'h4, 0, "R7 read counter");
    axi_read(32'h0, 0, "R7 write counter zero");

    // R3 basic write/read
    axi_write(32'h40, 32'hDEAD_BEEF, 0);
    axi_read(32'h40, 0, "R3 readback");
    known_q.push_back(16);

    // R9: word 2050 folds to 3, word 4100 folds to 6
    axi_write(32'd2050 << 2, 32'h1234_5678, 0);
    axi_read(32'd12, 0, "R9 fold 2050->3");
    axi_write(32'd6 << 2, 32'h0BAD_F00D, 0);
    axi_read(32'd4100 << 2, 0, "R9 fold 4100->6");
    axi_write(32'd2047 << 2, 32'hCAFE_0001, 1);
    axi_read(32'd2047 << 2, 1, "R9 top word not folded");
    known_q.push_back(3); known_q.push_back(6); known_q.push_back(2047);

    // R8: write to reserved word dropped, error sticky
    axi_write(32'h4, 32'hFFFF_FFFF, 0);
    axi_read(32'h8, 0, "R8 error word set");
    axi_read(32'h4, 0, "R8 read counter untouched");
    axi_read(32'h0, 0, "R7 write counter counts dropped");

    // R6: simultaneous write and read requests
    @(negedge clk);
    awaddr = 32'd100 << 2; wdata = 32'hA5A5_0F0F; awvalid = 1; wvalid = 1;
    araddr = 32'd100 << 2; arvalid = 1; bready = 1; rready = 1;
    #1;
    chk("R6 awready first", {31'd0, awready}, 1);
    chk("R6 arready held low", {31'd0, arready}, 0);
    @(posedge clk);
    @(negedge clk);
    awvalid = 0; wvalid = 0;
    wcnt++; exp_mem[100] = 32'hA5A5_0F0F;
    chk("R10 arready low while busy", {31'd0, arready}, 0);
    while (!bvalid) @(negedge clk);
    chk("R10 rvalid not with bvalid", {31'd0, rvalid}, 0);
    #1;
    while (!arready) begin
      @(negedge clk); #1;
    end
    @(posedge clk);
    @(negedge clk);
    arvalid = 0; rcnt++;
    while (!rvalid) @(negedge clk);
    chk("R6 read after write", rdata, 32'hA5A5_0F0F);
    @(negedge clk);
    known_q.push_back(100);

    // constrained random mix
    for (int n = 0; n < 300; n++) begin
      int unsigned pick;
      bit hold;
      pick = $urandom_range(0, 99);
      hold = ($urandom_range(0, 7) == 0);
      if (pick < 50) begin
        logic [31:0] a;
        int w;
        if (pick < 5) a = $urandom_range(0, 11);
        else if (pick < 15) a = $urandom();
        else a = 32'($urandom_range(3, DEPTH - 1)) << 2;
        w = fold(a);
        axi_write(a, $urandom(), hold);
        if (w >= 3) known_q.push_back(w);
      end else if (pick < 60) begin
        axi_read(32'($urandom_range(0, 2)) << 2, hold, "R7 random stats read");
      end else begin
        int w;
        logic [31:0] a;
        w = known_q[$urandom_range(0, known_q.size() - 1)];
        if (pick < 75) a = 32'(w + DEPTH - 1) << 2;
        else a = 32'(w) << 2;
        axi_read(a, hold, "R9 random readback");
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule